// File: doc/BRIEF.md
# Programmable Butterfly Permuter with Two-Input Lookup

This block transforms a 64-bit data word through six staged rows of a butterfly-style network. Row k pairs every bit j with the partner bit j XOR 2^k. A row is either bypassed or active, and the choice is made once for the whole row by one bit of a 6-bit control amount. In an active row each output bit comes from a 4-entry lookup table addressed by the bit itself and its partner. The table is shared by every bit and every row. One table setting turns the datapath into a generalised bit reverse. Another turns it into a generalised OR-combine. With a zero data word, other settings generate regular 64-bit constants from a short operand.

Words enter and leave through valid/ready streams. A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. It is delivered on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output word and `out_valid` hold. The parameter `PIPE_MASK` places a register slice after any chosen row. Each slice is a one-entry buffer whose ready signal is `!full || downstream_ready`, so back-pressure ripples upstream one slice per cycle without losing a word. Words leave in the order they arrived. With `PIPE_MASK` zero the block is purely combinational from input to output.

Top module: `bfly_lut_permuter`

## Requirements
- R1: The control amount is `in_shift[5:0]`, which is the operand modulo 64. Bits 63..6 of `in_shift` have no effect on the result.
- R2: Row k (step 2^k) is active only when bit k of the control amount is 1. Active rows are applied in increasing step order: 1, 2, 4, 8, 16, 32.
- R3: In an active row with step s, the new bit j is `tbl[{x[j^s], x[j]}]`. The index is LSB-0: the own bit is the low index bit and the partner bit is the high index bit.
- R4: Only `in_tbl[3:0]` is used. Bits 7..4 of `in_tbl` have no effect on the result.
- R5: When the control amount is 0, the output equals the input word, whatever the table value.
- R6: Table value 4'b1100 gives generalised reverse. Each active row with step s swaps the bits selected by the mask of positions with bit s clear against the bits with bit s set.
- R7: Table value 4'b1110 gives generalised OR-combine. Each active row replaces x with x OR (the row's swapped x).
- R8: When the data word is zero and `tbl[0]` is 1, the network generates a constant pattern. For example, data 0, table 4'b0001 and amount 1 give all ones.
- R9: Each accepted word produces exactly one output word, in arrival order. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged.
- R10: While reset is asserted and in the first cycle after it, no slice holds a word, so `out_valid` is 0 whenever at least one slice exists.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can accept the input word |
| in_data | input | 64 | Data word to transform |
| in_shift | input | 64 | Shift operand; its low 6 bits are the control amount |
| in_tbl | input | 8 | Table operand; its low 4 bits are the lookup table |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 64 | Transformed word |

## Verification
The hardest situation to reach is a stall that catches words in several register slices at once, while each word has a different control amount and table. A fault in the slice handshake or payload capture would then mix one word's table with another's data. To produce it, the stimulus sweeps every control amount against every table value over several data patterns. It throttles `out_ready` at random, low about a third of the time, and inserts random input gaps. Words therefore pile up behind stalled slices and drain in irregular bursts. Every delivered word is matched in order against a value computed arithmetically in the bench. The reverse and OR-combine cases are checked against swap-mask formulas instead of the lookup loop.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int unsigned TBL_W = 4;

  // Pick one table entry: partner bit is the high index bit, own bit the low one.
  function automatic logic lut2_pick(input logic [TBL_W-1:0] tbl,
                                     input logic own, input logic partner);
    return tbl[{partner, own}];
  endfunction
endpackage

// File: rtl/bfly_row.sv
module bfly_row
  import bfly_pkg::*;
#(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned STEP  = 1
) (
  input  logic [WIDTH-1:0] x_in,
  input  logic             row_en,
  input  logic [TBL_W-1:0] tbl,
  output logic [WIDTH-1:0] x_out
);
  for (genvar j = 0; j < WIDTH; j++) begin : g_bit
    localparam int unsigned PARTNER = j ^ STEP;
    assign x_out[j] = row_en ? lut2_pick(tbl, x_in[j], x_in[PARTNER]) : x_in[j];
  end
endmodule

// File: rtl/bfly_slot.sv
module bfly_slot #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [PW-1:0] up_data,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [PW-1:0] dn_data
);
  logic          full_q;
  logic [PW-1:0] data_q;

  assign up_ready = !full_q || dn_ready;
  assign dn_valid = full_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        full_q <= 1'b0;
    else if (up_ready) full_q <= up_valid;
  end

  always_ff @(posedge clk) begin
    if (up_ready && up_valid) data_q <= up_data;
  end

  // R9: a stalled word is neither lost nor altered
  p_keep_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> dn_valid);
  p_keep_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> $stable(dn_data));
endmodule

// File: rtl/bfly_lut_permuter.sv
module bfly_lut_permuter
  import bfly_pkg::*;
#(
  parameter int unsigned WIDTH     = 64,
  parameter int unsigned TBL_IN_W  = 8,
  parameter logic [5:0]  PIPE_MASK = 6'b100100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WIDTH-1:0]    in_data,
  input  logic [WIDTH-1:0]    in_shift,
  input  logic [TBL_IN_W-1:0] in_tbl,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [WIDTH-1:0]    out_data
);
  localparam int unsigned LOG2  = $clog2(WIDTH);
  localparam int unsigned PW    = WIDTH + LOG2 + TBL_W;
  localparam int unsigned NSLOT = $countones(PIPE_MASK[LOG2-1:0]);
  localparam int unsigned CNT_W = $clog2(NSLOT + 2);

  // Position p sits before row p; position LOG2 is the output.
  logic [WIDTH-1:0] x_p   [0:LOG2];
  logic [LOG2-1:0]  amt_p [0:LOG2];
  logic [TBL_W-1:0] tbl_p [0:LOG2];
  logic             v_p   [0:LOG2];
  logic             r_p   [0:LOG2];

  assign x_p[0]   = in_data;
  assign amt_p[0] = in_shift[LOG2-1:0];
  assign tbl_p[0] = in_tbl[TBL_W-1:0];
  assign v_p[0]   = in_valid;
  assign in_ready = r_p[0];

  assign out_data   = x_p[LOG2];
  assign out_valid  = v_p[LOG2];
  assign r_p[LOG2]  = out_ready;

  logic unused_hi;
  assign unused_hi = ^{in_shift[WIDTH-1:LOG2], in_tbl[TBL_IN_W-1:TBL_W],
                       amt_p[LOG2], tbl_p[LOG2]};

  for (genvar k = 0; k < LOG2; k++) begin : g_row
    logic [WIDTH-1:0] row_y;

    bfly_row #(.WIDTH(WIDTH), .STEP(1 << k)) u_row (
      .x_in  (x_p[k]),
      .row_en(amt_p[k][k]),
      .tbl   (tbl_p[k]),
      .x_out (row_y)
    );

    // R5/R2: a row whose amount bit is clear leaves the word untouched
    p_row_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !amt_p[k][k] |-> (row_y == x_p[k]));

    if (PIPE_MASK[k]) begin : g_reg
      logic [PW-1:0] dn_pl;
      bfly_slot #(.PW(PW)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_valid(v_p[k]),
        .up_ready(r_p[k]),
        .up_data ({row_y, amt_p[k], tbl_p[k]}),
        .dn_valid(v_p[k+1]),
        .dn_ready(r_p[k+1]),
        .dn_data (dn_pl)
      );
      assign {x_p[k+1], amt_p[k+1], tbl_p[k+1]} = dn_pl;
    end else begin : g_wire
      assign x_p[k+1]   = row_y;
      assign amt_p[k+1] = amt_p[k];
      assign tbl_p[k+1] = tbl_p[k];
      assign v_p[k+1]   = v_p[k];
      assign r_p[k]     = r_p[k+1];
    end
  end

  // Words in flight: never more than the number of slices (R9)
  logic [CNT_W-1:0] inflight_q;
  always_ff @(posedge clk) begin
    if (!rst_n) inflight_q <= '0;
    else begin
      case ({in_valid && in_ready, out_valid && out_ready})
        2'b10:   inflight_q <= inflight_q + 1'b1;
        2'b01:   inflight_q <= inflight_q - 1'b1;
        default: inflight_q <= inflight_q;
      endcase
    end
  end

  p_inflight_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q <= CNT_W'(NSLOT));
  p_no_output_when_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (NSLOT != 0 && inflight_q == '0) |-> !out_valid);

  if (NSLOT != 0) begin : g_rst_chk
    p_reset_empty_r10: assert property (@(posedge clk)
      !rst_n |=> !out_valid);
  end
endmodule

// File: tb/bfly_lut_permuter_test.sv
`timescale 1ns/1ps
module bfly_lut_permuter_test;
  localparam int W = 64;
  localparam int TOTAL = 64 * 16 * 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_data = '0;
  logic [W-1:0] in_shift = '0;
  logic [7:0]   in_tbl = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_data;

  always #2.5 clk = ~clk;

  bfly_lut_permuter uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_shift(in_shift), .in_tbl(in_tbl),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int checks = 0;
  int fails  = 0;

  logic [W-1:0] q_exp[$];
  string        q_tag[$];

  function automatic logic [W-1:0] lut_model(logic [W-1:0] d, logic [5:0] amt,
                                             logic [3:0] t);
    logic [W-1:0] x, nx;
    x = d;
    for (int k = 0; k < 6; k++) begin
      if (amt[k]) begin
        for (int j = 0; j < W; j++) nx[j] = t[{x[j ^ (1 << k)], x[j]}];
        x = nx;
      end
    end
    return x;
  endfunction

  function automatic logic [W-1:0] swap_row(logic [W-1:0] x, int s);
    logic [W-1:0] m;
    for (int j = 0; j < W; j++) m[j] = ((j & s) == 0);
    return ((x & m) << s) | ((x & ~m) >> s);
  endfunction

  function automatic logic [W-1:0] mask_model(logic [W-1:0] d, logic [5:0] amt,
                                              bit or_mode);
    logic [W-1:0] x;
    x = d;
    for (int k = 0; k < 6; k++)
      if (amt[k]) x = or_mode ? (x | swap_row(x, 1 << k)) : swap_row(x, 1 << k);
    return x;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [W-1:0] pat [0:3];
  initial begin
    pat[0] = '0;
    pat[1] = 64'h0123_4567_89AB_CDEF;
    pat[2] = 64'h8000_0000_0000_0001;
    pat[3] = 64'hF0E1_D2C3_B4A5_9687;
  end

  initial begin
    int  item = 0;
    int  cyc = 0;
    bit  accepted = 0;
    bit  prev_stall = 0;
    logic [W-1:0] prev_data = '0;
    logic [W-1:0] exp;
    string tag;

    repeat (3) @(negedge clk);
    // R10: empty during reset
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10 actual=%b expected=0", out_valid);
    end
    @(negedge clk) rst_n = 1'b1;
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10 actual=%b expected=0 after reset", out_valid);
    end

    while (item < TOTAL || in_valid || q_exp.size() != 0) begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d cycles expected<150000", cyc);
        break;
      end
      if (accepted) begin
        in_valid = 1'b0;
        accepted = 0;
      end
      if (!in_valid && item < TOTAL && ($urandom % 4) != 0) begin
        logic [5:0] amt;
        logic [3:0] t;
        amt = 6'(item % 64);
        t   = 4'((item / 64) % 16);
        in_data  = pat[item / 1024];
        in_shift = {($urandom % 2) ? {$urandom, 26'($urandom)} : 58'd0, amt};
        in_tbl   = {($urandom % 2) ? 4'($urandom) : 4'd0, t};
        in_valid = 1'b1;
        item++;
      end
      out_ready = ($urandom % 10) > 2;
      #1;
      if (prev_stall) begin
        // R9: held while stalled
        check("R9", {63'd0, out_valid}, 64'd1);
        check("R9", out_data, prev_data);
      end
      if (in_valid && in_ready) begin
        logic [5:0] amt;
        logic [3:0] t;
        amt = in_shift[5:0];
        t   = in_tbl[3:0];
        if (amt == 0) begin
          exp = in_data; tag = "R5";
        end else if (t == 4'b1100) begin
          exp = mask_model(in_data, amt, 1'b0); tag = "R6";
        end else if (t == 4'b1110) begin
          exp = mask_model(in_data, amt, 1'b1); tag = "R7";
        end else if (in_data == 0 && t[0]) begin
          exp = lut_model(in_data, amt, t); tag = "R8";
          if (amt == 6'd1 && t == 4'b0001) exp = '1;
        end else begin
          exp = lut_model(in_data, amt, t);
          if (in_shift[W-1:6] != 0)  tag = "R1";
          else if (in_tbl[7:4] != 0) tag = "R4";
          else if ($countones(amt) > 1) tag = "R2";
          else tag = "R3";
        end
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        accepted = 1;
      end
      if (out_valid && out_ready) begin
        if (q_exp.size() == 0) begin
          checks++; fails++;
          $display("FAIL R9 actual=extra word %h expected=none", out_data);
        end else begin
          exp = q_exp.pop_front();
          tag = q_tag.pop_front();
          check(tag, out_data, exp);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule